// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits in front of a data converter's output path. It chooses the word sent each sample clock. With no test selected it forwards the converter's own sample. With a test selected it sends a synthetic word instead, and it raises a flag for as long as test data is being sent. The synthetic words are:

- fixed midscale and full-scale codes
- alternating bit patterns
- two pseudo-random sequences that can each be held at their seed
- a sequencer that plays back two user words

A 4-bit select picks the pattern. A 2-bit field controls how the user words are played back. A format input chooses between offset binary and two's complement, and it changes only the midscale and full-scale words. The output word and the flag are both registered. Each therefore reflects the inputs sampled on the previous clock edge.

Top module: `conv_tpg`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `test_active` is 0.
- R2: With `sel` = 0000, and also for the unused codes 1101, 1110 and 1111, `dout` equals `adc_data` from one edge earlier and `test_active` is 0. For every other `sel` code `test_active` is 1, except where R10 or R11 says otherwise. Every output follows the inputs with one cycle of latency.
- R3: When `twos_comp` = 0, the fixed codes give these words: `sel` 0001 gives 0x800, 0010 gives 0xFFF and 0011 gives 0x000. When `twos_comp` = 1 the MSB of each of these three words is inverted, giving 0x000, 0x7FF and 0x800.
- R4: A phase bit clears at reset and flips on every clock edge. When the phase is 0, `sel` 0100 gives 0xAAA, 0111 gives 0xFFF and 1100 gives 0xA95. When the phase is 1, each of these gives the bitwise complement of its phase-0 word.
- R5: `sel` 1001 gives a constant 0xAAA, 1010 gives a constant 0xFC0, and 1011 gives a constant 0x800.
- R6: `sel` 0110 outputs a 12-bit shift register. The register starts at all ones and shifts left every clock. The bit shifted in is bit 8 XOR bit 4, which is the sequence x^9+x^5+1.
- R7: `sel` 0101 outputs bits 22 down to 11 of a 23-bit shift register. The register starts at all ones and shifts left every clock. The bit shifted in is bit 22 XOR bit 17, which is the sequence x^23+x^18+1.
- R8: While `pn_short_hold` is 1, the register of R6 is loaded with all ones on each clock edge. `pn_long_hold` does the same for the register of R7. Both generators run continuously whichever pattern is selected.
- R9: `sel` 1000 plays back the user words. With `user_mode` 00 it sends `user_word0` on every sample. With `user_mode` 01 it sends `user_word0`, then `user_word1`, and keeps alternating. Any change of `sel` or `user_mode` restarts the sequence at `user_word0`.
- R10: With `sel` 1000 and `user_mode` 10, `user_word0` is sent once. After that the block returns to normal data and `test_active` goes to 0.
- R11: With `sel` 1000 and `user_mode` 11, `user_word0` is sent and then `user_word1` is sent. After that the block returns to normal data and `test_active` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Pattern select |
| user_mode | input | 2 | User-word playback mode |
| user_word0 | input | 12 | First user word |
| user_word1 | input | 12 | Second user word |
| pn_long_hold | input | 1 | Holds the 23-bit generator at its seed |
| pn_short_hold | input | 1 | Holds the 9-bit generator at its seed |
| twos_comp | input | 1 | Selects two's-complement format for the fixed codes |
| adc_data | input | 12 | Normal converter sample |
| dout | output | 12 | Output word |
| test_active | output | 1 | High while `dout` carries test data |

## Verification
The assertions check five rules on every cycle:

- the flag stays low for the pass-through code and the unused codes
- the midscale word matches the selected format
- checkerboard words alternate from sample to sample
- the short generator outputs all ones while its hold is set
- a single-shot user sequence ends after one word

The bench's scenarios are needed for the rest. Each pseudo-random sequence must be tracked step by step against the polynomial. The one-word and two-word user sequences must restart after a change of configuration. The phase relationship across pattern switches must be seen, and the format change must be checked on every full-scale code.

// File: rtl/conv_tpg.sv
module conv_tpg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   sel,
  input  logic [1:0]   user_mode,
  input  logic [W-1:0] user_word0,
  input  logic [W-1:0] user_word1,
  input  logic         pn_long_hold,
  input  logic         pn_short_hold,
  input  logic         twos_comp,
  input  logic [W-1:0] adc_data,
  output logic [W-1:0] dout,
  output logic         test_active
);
  localparam logic [W-1:0] ALT  = {(W/2){2'b10}};
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MSB  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SYNC = {{(W/2){1'b1}}, {(W/2){1'b0}}};
  localparam logic [W-1:0] MIX  = ALT ^ {{(W/2){1'b0}}, {(W/2){1'b1}}};

  logic         ph;
  logic [W-1:0] pn9;
  logic [22:0]  pn23;
  logic [5:0]   cfg_q;
  logic [1:0]   cnt, idx, cnt_nx;
  logic [W-1:0] word, fs_flip;
  logic         act;

  assign idx     = ({sel, user_mode} != cfg_q) ? 2'd0 : cnt;
  assign fs_flip = twos_comp ? MSB : '0;
  assign cnt_nx  = (user_mode == 2'b01) ? {1'b0, ~idx[0]} :
                   (idx == 2'd2) ? 2'd2 : idx + 2'd1;

  always_comb begin
    word = adc_data;
    act  = 1'b1;
    case (sel)
      4'h1: word = MSB ^ fs_flip;
      4'h2: word = ONES ^ fs_flip;
      4'h3: word = fs_flip;
      4'h4: word = ph ? ~ALT : ALT;
      4'h5: word = pn23[22 -: W];
      4'h6: word = pn9;
      4'h7: word = ph ? '0 : ONES;
      4'h8: begin
        case (user_mode)
          2'b00: word = user_word0;
          2'b01: word = idx[0] ? user_word1 : user_word0;
          2'b10: begin
            act = (idx == 2'd0);
            if (act) word = user_word0;
          end
          default: begin
            act = (idx != 2'd2);
            if (idx == 2'd0) word = user_word0;
            else if (idx == 2'd1) word = user_word1;
          end
        endcase
      end
      4'h9: word = ALT;
      4'hA: word = SYNC;
      4'hB: word = MSB;
      4'hC: word = ph ? ~MIX : MIX;
      default: act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= 1'b0;
      pn9         <= '1;
      pn23        <= '1;
      cfg_q       <= '0;
      cnt         <= '0;
      dout        <= '0;
      test_active <= 1'b0;
    end else begin
      ph          <= ~ph;
      pn9         <= pn_short_hold ? '1 : {pn9[W-2:0], pn9[8] ^ pn9[4]};
      pn23        <= pn_long_hold ? '1 : {pn23[21:0], pn23[22] ^ pn23[17]};
      cfg_q       <= {sel, user_mode};
      cnt         <= cnt_nx;
      dout        <= word;
      test_active <= act;
    end
  end
endmodule

module conv_tpg_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   sel,
  input logic [1:0]   user_mode,
  input logic         twos_comp,
  input logic         pn_short_hold,
  input logic [W-1:0] dout,
  input logic         test_active
);
  p_idle_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'h0 || sel >= 4'hD) |=> !test_active);

  p_midscale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'h1) |=> dout == {~$past(twos_comp), {(W-1){1'b0}}});

  p_checker_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'h4 && $past(sel) == 4'h4 && test_active) |=> dout == ~$past(dout));

  p_short_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pn_short_hold) && sel == 4'h6) |=> dout == {W{1'b1}});

  p_single_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'h8 && user_mode == 2'b10 && $past(sel) == 4'h8 && $past(user_mode) == 2'b10)
      |=> !test_active);
endmodule

bind conv_tpg conv_tpg_chk #(.W(W)) u_chk (.*);

// File: tb/conv_tpg_tb.sv
`timescale 1ns/1ps
module conv_tpg_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0]  sel = 0;
  logic [1:0]  user_mode = 0;
  logic [11:0] user_word0 = 12'h123, user_word1 = 12'hDEF, adc_data = 0;
  logic pn_long_hold = 0, pn_short_hold = 0, twos_comp = 0;
  logic [11:0] dout;
  logic test_active;
  int checks = 0, errors = 0;

  logic        m_ph;
  logic [11:0] m_pn9;
  logic [22:0] m_pn23;
  logic [5:0]  m_cfg;
  logic [1:0]  m_cnt;

  always #2 clk = ~clk;

  conv_tpg u_dut (.*);

  function automatic string tag(input logic [3:0] s, input logic [1:0] m);
    case (s)
      4'h1, 4'h2, 4'h3: return "R3";
      4'h4, 4'h7, 4'hC: return "R4";
      4'h9, 4'hA, 4'hB: return "R5";
      4'h5: return "R7/R8";
      4'h6: return "R6/R8";
      4'h8: return (m == 2'b10) ? "R10" : (m == 2'b11) ? "R11" : "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string r, input logic [11:0] ed, input logic ea);
    checks++;
    if (dout !== ed || test_active !== ea) begin
      errors++;
      $display("FAIL %s: dout=%h active=%b expected dout=%h active=%b", r, dout, test_active, ed, ea);
    end
  endtask

  task automatic step();
    logic [11:0] ed;
    logic ea;
    logic [1:0] i;
    logic [11:0] flip;
    i = ({sel, user_mode} != m_cfg) ? 2'd0 : m_cnt;
    flip = twos_comp ? 12'h800 : 12'h000;
    ea = 1'b1;
    ed = adc_data;
    case (sel)
      4'h1: ed = 12'h800 ^ flip;
      4'h2: ed = 12'hFFF ^ flip;
      4'h3: ed = 12'h000 ^ flip;
      4'h4: ed = m_ph ? 12'h555 : 12'hAAA;
      4'h5: ed = m_pn23[22:11];
      4'h6: ed = m_pn9;
      4'h7: ed = m_ph ? 12'h000 : 12'hFFF;
      4'h8: case (user_mode)
        2'b00: ed = user_word0;
        2'b01: ed = i[0] ? user_word1 : user_word0;
        2'b10: if (i == 0) ed = user_word0; else ea = 0;
        default: if (i == 0) ed = user_word0; else if (i == 1) ed = user_word1; else ea = 0;
      endcase
      4'h9: ed = 12'hAAA;
      4'hA: ed = 12'hFC0;
      4'hB: ed = 12'h800;
      4'hC: ed = m_ph ? 12'h56A : 12'hA95;
      default: ea = 0;
    endcase
    @(posedge clk);
    m_ph   = ~m_ph;
    m_pn9  = pn_short_hold ? 12'hFFF : {m_pn9[10:0], m_pn9[8] ^ m_pn9[4]};
    m_pn23 = pn_long_hold ? '1 : {m_pn23[21:0], m_pn23[22] ^ m_pn23[17]};
    m_cfg  = {sel, user_mode};
    m_cnt  = (user_mode == 2'b01) ? {1'b0, ~i[0]} : (i == 2) ? 2'd2 : i + 2'd1;
    @(negedge clk);
    check(tag(sel, user_mode), ed, ea);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc = 0;
    sel = 4'h5;
    adc_data = 12'h777;
    repeat (3) @(negedge clk);
    check("R1", 12'h000, 1'b0);
    sel = 0;
    m_ph = 0; m_pn9 = '1; m_pn23 = '1; m_cfg = 0; m_cnt = 0;
    rst_n = 1;
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 16; s++) begin
        for (int m = 0; m < 4; m++) begin
          twos_comp = f[0];
          sel = s[3:0];
          user_mode = m[1:0];
          for (int k = 0; k < 24; k++) begin
            cyc++;
            adc_data = 12'(cyc * 37 + 5);
            user_word0 = 12'(cyc * 11 + 1);
            user_word1 = ~user_word0;
            pn_short_hold = (k >= 5 && k < 8) || (k == 14);
            pn_long_hold = (k >= 9 && k < 12);
            step();
          end
        end
      end
    end
    pn_short_hold = 0;
    pn_long_hold = 0;
    for (int s = 0; s < 16; s++) begin
      sel = s[3:0];
      repeat (2) step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule